// File: doc/BRIEF.md
# Polled Register Bridge to a Slow Domain

This block lets a host on a fast register bus reach registers that live in a slow, always-on domain, such as a real-time clock or a power controller. The host does not see those registers directly. It works through a small window of four host registers: one for the target address, one for the access kind and byte lanes, one for data, and one for control and status. It loads the address and the access kind, and for a write also the data. It then sets a start bit and polls the control register until it reads zero.

For each start, the bridge runs exactly one request/acknowledge exchange on a simple slow-side register port. The slow side may take any number of cycles to acknowledge. On a read, the returned word is captured into the data register. While an exchange is in flight, the bridge refuses any change to its window, so the request on the slow side stays intact.

Top module: `slow_reg_bridge`

## Requirements
- R1: Host offsets are decoded exactly. 0x0 is control/status, with bit 0 as the busy flag. 0x4 is the access-kind register (8 bits). 0x8 is the target address (TADDR_W bits). 0xC is the 32-bit data register. Reads return these values zero-extended.
- R2: A host write to offset 0x0 with bit 0 set starts exactly one slow-side exchange when the bridge is idle. A write with bit 0 clear starts nothing. Control reads 1 while an exchange is in flight and 0 when idle.
- R3: Bit 0 of the access-kind register is the write flag and drives `s_we`. Bits 7:4 are byte-lane enables and drive `s_be`, with bit 4 for byte 0. The value 0x00 is a read. The value 0xF1 is a full-word write.
- R4: On a write exchange, `s_wdata` carries the data register and `s_addr` carries the target-address register.
- R5: When a read exchange is acknowledged, the data register takes `s_rdata` and holds it. Once control reads 0, the host reads that value at offset 0xC.
- R6: `s_req` stays high, with `s_addr`, `s_wdata`, `s_we` and `s_be` unchanged, from the cycle after the start write until the cycle in which `s_ack` is high.
- R7: `s_req` falls, and busy clears, in the cycle after `s_ack` is sampled high. Busy therefore lasts exactly L+2 cycles when the slow side acknowledges L cycles after it first sees the request.
- R8: A start written while busy is ignored and starts no second exchange.
- R9: Host writes to the address, access-kind and data registers while busy are ignored.
- R10: After reset, busy is clear, `s_req` is low and all four registers read 0. Reads of any other offset, including misaligned ones, return 0.
- R11: Only the byte lanes whose enables are set are written on the slow side. A write with all four enables clear leaves the target word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | HOFS_W | Host byte offset |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data |
| s_req | output | 1 | Slow-side request |
| s_we | output | 1 | Slow-side write flag |
| s_be | output | DATA_W/8 | Slow-side byte-lane enables |
| s_addr | output | TADDR_W | Slow-side register address |
| s_wdata | output | DATA_W | Slow-side write data |
| s_ack | input | 1 | Slow-side acknowledge |
| s_rdata | input | DATA_W | Slow-side read data |

## Verification
Full-word writes followed by reads are swept over every slow-side address and over acknowledge latencies from 0 to 3. A fault in the address path shows up as aliasing between addresses. A fault in the busy timing shows up as a wrong busy length at one of the latencies. All sixteen byte-enable patterns are applied over a known base word, so lane ordering, lane masking and the empty-mask case give different merged words. A long-latency exchange is hit with writes and a second start while busy, which separates "ignored" from "applied late" and from "started twice". Unmapped and misaligned offsets are read while the window holds nonzero values.

// File: rtl/srb_pkg.sv
package srb_pkg;
   // host window byte offsets; software depends on these positions
   localparam int OFS_CTRL = 'h0;
   localparam int OFS_KIND = 'h4;
   localparam int OFS_TADR = 'h8;
   localparam int OFS_DATA = 'hC;

   // position of the byte-lane enable field in the access-kind register
   localparam int KIND_BE_LSB = 4;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } srb_state_e;
endpackage

// File: rtl/srb_regs.sv
module srb_regs
   import srb_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TADDR_W   = 16,
   parameter int HOFS_W    = 6,
   parameter int RDATA_REG = 0,
   localparam int BE_W     = DATA_W / 8,
   localparam int KIND_W   = KIND_BE_LSB + BE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_sel,
   input  logic               h_wr,
   input  logic [HOFS_W-1:0]  h_addr,
   input  logic [DATA_W-1:0]  h_wdata,
   output logic [DATA_W-1:0]  h_rdata,
   input  logic               busy_i,
   input  logic               rd_cap_i,
   input  logic [DATA_W-1:0]  rd_data_i,
   output logic               start_o,
   output logic [TADDR_W-1:0] taddr_o,
   output logic               we_o,
   output logic [BE_W-1:0]    be_o,
   output logic [DATA_W-1:0]  wdata_o
);
   logic [TADDR_W-1:0] taddr_q;
   logic [KIND_W-1:0]  kind_q;
   logic [DATA_W-1:0]  data_q;
   logic [DATA_W-1:0]  rd_mux;
   logic hit_ctrl, hit_kind, hit_tadr, hit_data, wr_ok;

   assign hit_ctrl = h_sel && (h_addr == HOFS_W'(OFS_CTRL));
   assign hit_kind = h_sel && (h_addr == HOFS_W'(OFS_KIND));
   assign hit_tadr = h_sel && (h_addr == HOFS_W'(OFS_TADR));
   assign hit_data = h_sel && (h_addr == HOFS_W'(OFS_DATA));
   assign wr_ok    = h_wr && !busy_i;

   assign start_o  = wr_ok && hit_ctrl && h_wdata[0];
   assign taddr_o  = taddr_q;
   assign we_o     = kind_q[0];
   assign be_o     = kind_q[KIND_BE_LSB +: BE_W];
   assign wdata_o  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taddr_q <= '0;
         kind_q  <= '0;
         data_q  <= '0;
      end else begin
         if (wr_ok && hit_tadr) taddr_q <= h_wdata[TADDR_W-1:0];
         if (wr_ok && hit_kind) kind_q  <= h_wdata[KIND_W-1:0];
         if (rd_cap_i)               data_q <= rd_data_i;
         else if (wr_ok && hit_data) data_q <= h_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_ctrl)      rd_mux[0]          = busy_i;
      else if (hit_kind) rd_mux[KIND_W-1:0] = kind_q;
      else if (hit_tadr) rd_mux[TADDR_W-1:0] = taddr_q;
      else if (hit_data) rd_mux             = data_q;
   end

   generate
      if (RDATA_REG != 0) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign h_rdata = rd_q;
      end else begin : g_rd_comb
         assign h_rdata = rd_mux;
      end
   endgenerate

   // window frozen while an exchange is in flight (R9)
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(taddr_q) && $stable(kind_q));
   p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && !rd_cap_i |=> $stable(data_q));
   // read result lands in the data register (R5)
   p_rd_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cap_i |=> data_q == $past(rd_data_i));
endmodule

// File: rtl/srb_seq.sv
module srb_seq
   import srb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TADDR_W = 16,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [TADDR_W-1:0] taddr_i,
   input  logic               we_i,
   input  logic [BE_W-1:0]    be_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic               s_req,
   output logic [TADDR_W-1:0] s_addr,
   output logic               s_we,
   output logic [BE_W-1:0]    s_be,
   output logic [DATA_W-1:0]  s_wdata,
   input  logic               s_ack,
   input  logic [DATA_W-1:0]  s_rdata,
   output logic               busy_o,
   output logic               rd_cap_o,
   output logic [DATA_W-1:0]  rd_data_o
);
   srb_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) state_q <= ST_WAIT;
            ST_WAIT: if (s_ack)   state_q <= ST_IDLE;
            default:              state_q <= ST_IDLE;
         endcase
      end
   end

   assign s_req     = (state_q == ST_WAIT);
   assign busy_o    = s_req;
   assign s_addr    = taddr_i;
   assign s_we      = we_i;
   assign s_be      = be_i;
   assign s_wdata   = wdata_i;
   assign rd_cap_o  = s_req && s_ack && !we_i;
   assign rd_data_o = s_rdata;

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !s_req |=> s_req);
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_req && !s_ack |=> s_req && $stable(s_addr) && $stable(s_wdata)
                          && $stable(s_we) && $stable(s_be));
   p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s_req && s_ack |=> !s_req);
   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !s_req && !start_i |=> !s_req);
endmodule

// File: rtl/slow_reg_bridge.sv
module slow_reg_bridge
   import srb_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TADDR_W   = 16,
   parameter int HOFS_W    = 6,
   parameter int RDATA_REG = 0,
   localparam int BE_W     = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_sel,
   input  logic               h_wr,
   input  logic [HOFS_W-1:0]  h_addr,
   input  logic [DATA_W-1:0]  h_wdata,
   output logic [DATA_W-1:0]  h_rdata,
   output logic               s_req,
   output logic               s_we,
   output logic [BE_W-1:0]    s_be,
   output logic [TADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0]  s_wdata,
   input  logic               s_ack,
   input  logic [DATA_W-1:0]  s_rdata
);
   generate
      if (DATA_W % 8 != 0 || KIND_BE_LSB + BE_W > DATA_W) begin : g_bad_data_w
         $error("slow_reg_bridge: DATA_W must be whole bytes and hold the kind field");
      end
      if (TADDR_W < 1 || TADDR_W > DATA_W) begin : g_bad_taddr_w
         $error("slow_reg_bridge: TADDR_W must be 1..DATA_W");
      end
      if (HOFS_W < 4) begin : g_bad_hofs_w
         $error("slow_reg_bridge: HOFS_W must reach offset 0xC");
      end
   endgenerate

   logic               start, busy, rd_cap, we;
   logic [TADDR_W-1:0] taddr;
   logic [BE_W-1:0]    be;
   logic [DATA_W-1:0]  wdata, rd_data;

   srb_regs #(
      .DATA_W(DATA_W), .TADDR_W(TADDR_W), .HOFS_W(HOFS_W), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .busy_i(busy), .rd_cap_i(rd_cap), .rd_data_i(rd_data),
      .start_o(start), .taddr_o(taddr), .we_o(we), .be_o(be), .wdata_o(wdata)
   );

   srb_seq #(
      .DATA_W(DATA_W), .TADDR_W(TADDR_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .taddr_i(taddr), .we_i(we), .be_i(be), .wdata_i(wdata),
      .s_req(s_req), .s_addr(s_addr), .s_we(s_we), .s_be(s_be), .s_wdata(s_wdata),
      .s_ack(s_ack), .s_rdata(s_rdata),
      .busy_o(busy), .rd_cap_o(rd_cap), .rd_data_o(rd_data)
   );
endmodule

// File: tb/slow_reg_bridge_tb.sv
module slow_reg_bridge_tb;
   localparam int DW = 32;
   localparam int AW = 16;
   localparam int HW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_sel = 1'b0, h_wr = 1'b0;
   logic [HW-1:0] h_addr = '0;
   logic [DW-1:0] h_wdata = '0;
   logic [DW-1:0] h_rdata;
   logic          s_req, s_we, s_ack;
   logic [3:0]    s_be;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_wdata, s_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int lat    = 0;
   int cnt    = 0;
   int txn_cnt = 0;
   logic [3:0]    last_be;
   logic          last_we;
   logic [AW-1:0] last_addr;
   logic [DW-1:0] mem [16];
   logic [DW-1:0] exp_mem [16];

   always #10 clk = ~clk;

   slow_reg_bridge #(.DATA_W(DW), .TADDR_W(AW), .HOFS_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .s_req(s_req), .s_we(s_we),
      .s_be(s_be), .s_addr(s_addr), .s_wdata(s_wdata), .s_ack(s_ack),
      .s_rdata(s_rdata)
   );

   // slow-side register model: acknowledges lat cycles after it first sees req
   assign s_rdata = mem[s_addr[3:0]];
   always @(posedge clk) begin
      if (!rst_n) begin
         s_ack <= 1'b0;
         cnt   <= 0;
         for (int i = 0; i < 16; i++) mem[i] <= '0;
      end else begin
         s_ack <= 1'b0;
         if (s_req && !s_ack) begin
            if (cnt >= lat) begin
               s_ack     <= 1'b1;
               cnt       <= 0;
               txn_cnt   <= txn_cnt + 1;
               last_be   <= s_be;
               last_we   <= s_we;
               last_addr <= s_addr;
               if (s_we)
                  for (int b = 0; b < 4; b++)
                     if (s_be[b]) mem[s_addr[3:0]][8*b +: 8] <= s_wdata[8*b +: 8];
            end else begin
               cnt <= cnt + 1;
            end
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog act=%0d exp=<150000", cycles);
         finish_run();
      end
   end

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic hw(input int ofs, input logic [DW-1:0] d);
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b1; h_addr = HW'(ofs); h_wdata = d;
      @(negedge clk);
      h_sel = 1'b0; h_wr = 1'b0;
   endtask

   task automatic hr(input int ofs, output logic [DW-1:0] d);
      h_sel = 1'b1; h_wr = 1'b0; h_addr = HW'(ofs);
      #1 d = h_rdata;
      h_sel = 1'b0;
   endtask

   task automatic wait_idle(output int busy_cyc);
      logic [DW-1:0] v;
      busy_cyc = 0;
      for (int k = 0; k < 200; k++) begin
         hr('h0, v);
         if (v == 0) break;
         busy_cyc++;
         @(negedge clk);
      end
   endtask

   // one exchange; checks busy length (R7) and what the slow side saw (R3, R4)
   task automatic txn(input logic [AW-1:0] a, input logic [7:0] kind, input logic [DW-1:0] d);
      int bc;
      hw('h8, DW'(a));
      hw('h4, DW'(kind));
      if (kind[0]) hw('hC, d);
      hw('h0, 32'h1);
      wait_idle(bc);
      chk(DW'(bc), DW'(lat + 2), "R7 busy length");
      chk(DW'(last_we), DW'(kind[0]), "R3 write flag");
      chk(DW'(last_be), DW'(kind[7:4]), "R3 byte enables");
      chk(DW'(last_addr), DW'(a), "R4 slow address");
      chk(DW'(s_req), 32'h0, "R7 req low when idle");
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [3:0] be);
      logic [DW-1:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
      return r;
   endfunction

   initial begin
      logic [DW-1:0] v;
      int t0;
      int bc;
      for (int i = 0; i < 16; i++) exp_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk(DW'(s_req), 32'h0, "R10 req after reset");
      for (int o = 0; o < 16; o += 4) begin
         hr(o, v);
         chk(v, 32'h0, "R10 register after reset");
      end

      // R2: control write with bit 0 clear starts nothing
      t0 = txn_cnt;
      hw('h0, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      hr('h0, v);
      chk(v, 32'h0, "R2 ctrl stays idle");
      chk(DW'(txn_cnt - t0), 32'h0, "R2 no exchange for bit0=0");

      // R4, R5, R7, R3: full-word writes then reads over all addresses and latencies
      for (int l = 0; l < 4; l++) begin
         lat = l;
         for (int a = 0; a < 16; a++) begin
            v = {8'(a), 8'(l), 8'hA5, 8'(a ^ (l << 2))};
            txn(AW'(a), 8'hF1, v);
            exp_mem[a] = v;
         end
         for (int a = 0; a < 16; a++) begin
            txn(AW'(a), 8'h00, 32'h0);
            hr('hC, v);
            chk(v, exp_mem[a], "R5 read data");
         end
      end

      // R1: window readback with known values
      lat = 1;
      hw('h8, 32'hFFFF_1234);
      hw('h4, 32'hFFFF_FF35);
      hw('hC, 32'hDEAD_BEEF);
      hr('h8, v); chk(v, 32'h0000_1234, "R1 address readback");
      hr('h4, v); chk(v, 32'h0000_0035, "R1 kind readback");
      hr('hC, v); chk(v, 32'hDEAD_BEEF, "R1 data readback");

      // R10: unmapped and misaligned offsets read 0
      hr('h10, v); chk(v, 32'h0, "R10 unmapped 0x10");
      hr('h3C, v); chk(v, 32'h0, "R10 unmapped 0x3C");
      hr('h1,  v); chk(v, 32'h0, "R10 misaligned 0x1");
      hr('hD,  v); chk(v, 32'h0, "R10 misaligned 0xD");

      // R11, R3: every byte-enable pattern over a known base word
      for (int be = 0; be < 16; be++) begin
         txn(AW'(5), 8'hF1, 32'hCAFE_F00D);
         txn(AW'(5), {4'(be), 4'b0001}, 32'h5A6B_7C8D);
         txn(AW'(5), 8'h00, 32'h0);
         hr('hC, v);
         chk(v, merge(32'hCAFE_F00D, 32'h5A6B_7C8D, 4'(be)), "R11 lane merge");
      end
      exp_mem[5] = merge(32'hCAFE_F00D, 32'h5A6B_7C8D, 4'hF);

      // R8, R9: writes and a second start while busy are ignored
      lat = 6;
      hw('h8, 32'h3);
      hw('h4, 32'hF1);
      hw('hC, 32'h1357_9BDF);
      t0 = txn_cnt;
      hw('h0, 32'h1);
      hw('h8, 32'h9);
      hw('h4, 32'h0);
      hw('hC, 32'h2468_ACE0);
      hw('h0, 32'h1);
      wait_idle(bc);
      repeat (10) @(negedge clk);
      chk(DW'(txn_cnt - t0), 32'h1, "R8 single exchange");
      chk(DW'(last_addr), 32'h3, "R9 address in flight kept");
      hr('h8, v); chk(v, 32'h3, "R9 address write ignored");
      hr('h4, v); chk(v, 32'hF1, "R9 kind write ignored");
      hr('hC, v); chk(v, 32'h1357_9BDF, "R9 data write ignored");
      lat = 0;
      txn(AW'(3), 8'h00, 32'h0);
      hr('hC, v); chk(v, 32'h1357_9BDF, "R4 written word at address 3");
      txn(AW'(9), 8'h00, 32'h0);
      hr('hC, v); chk(v, exp_mem[9], "R9 address 9 untouched");

      finish_run();
   end
endmodule